// File: doc/BRIEF.md
# Back-Trace Capture Ring Buffer

This block sits beside a processor's trace outputs and keeps a rolling history of program flow. On every clock it stores one status record holding the processor's flow-status and flush-status codes. On any cycle that carries the trace attribute it also stores a second record holding the bus address. Records go into a circular store that overwrites the oldest entries, so the most recent history is always held.

Capture starts on the first clock after reset is released. External logic raises the sync input some time after reset and drops it when the event of interest happens. That falling edge ends the capture, either at once or after a set number of extra cycles, and the store is frozen. A host then drains the frozen records from oldest to newest through a simple valid/advance read port. A host clear rearms capture for another run.

Top module: `trace_ring_capture`

## Requirements
- R1: Out of reset, `frozen`, `full` and `rd_valid` are low. Capture is active from the first rising clock edge at which `rst_n` is high.
- R2: On every capturing cycle one status record is written. Its bit REC_W-1 (the type bit) is 0, bits [4:2] hold `flow_stat`, bits [1:0] hold `flush_stat`, and all other bits are 0.
- R3: On a capturing cycle with `trace_mark` high, an address record is also written: the type bit is 1 and the low ADDR_W bits hold `bus_addr`. In storage order it follows that cycle's status record.
- R4: An event is a rising edge at which `sync_in` is low after being high at the previous edge. With POST_CYC = 0, that cycle's records are kept, nothing after it is written, and `frozen` is high from that edge on. A low `sync_in` that was never high, and any edge after the first event, have no effect.
- R5: The store holds DEPTH records and overwrites the oldest one first. `full` rises once the total written since clear reaches DEPTH, and it stays high until a clear.
- R6: While frozen, `rd_valid` is high as long as records remain and `rd_data` shows the oldest record not yet read. A rising edge with `rd_en` high advances to the next record. The record count is min(written, DEPTH), after which `rd_valid` drops.
- R7: `rd_en` has no effect before freeze: the readout still starts at the oldest record.
- R8: `host_clr` high at a rising edge writes no record and clears `frozen`, `full`, `rd_valid` and the pointers. Capture resumes at the next edge.
- R9: With POST_CYC = N > 0, the records of the N cycles that follow the event cycle are also kept, and `frozen` rises at the edge of the last of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flow_stat | input | FLOW_W | Processor flow-status code, sampled every cycle |
| flush_stat | input | FLUSH_W | Processor flush-status code, sampled every cycle |
| trace_mark | input | 1 | Current bus cycle carries the trace attribute |
| bus_addr | input | ADDR_W | Bus address of the current cycle |
| sync_in | input | 1 | Trace window; its falling edge is the event |
| host_clr | input | 1 | Rearm capture and clear pointers and flags |
| rd_en | input | 1 | Advance to the next frozen record |
| rd_data | output | REC_W | Oldest unread frozen record |
| rd_valid | output | 1 | A frozen record is available on rd_data |
| frozen | output | 1 | Capture has stopped |
| full | output | 1 | The store has wrapped at least once |

## Verification
Each record lands in storage at the rising edge where its inputs are presented. The bench drives inputs at the falling edge and reads outputs at the next falling edge, one half period after the edge that changed them. `frozen` is due at the event edge itself, and N edges later for the post-trigger instance. `full` is due at the same edge as the write that wraps, and each advance shows on `rd_data` after a single edge. The bench keeps a history of every record it presented, tagged with its cycle, and derives from it what each instance should hold: the last DEPTH records up to the event cycle plus POST_CYC.

// File: rtl/trc_pkg.sv
package trc_pkg;

    typedef enum logic [1:0] {
        TRC_CAP  = 2'd0,
        TRC_POST = 2'd1,
        TRC_HOLD = 2'd2
    } trc_state_e;

    localparam logic TYPE_STATUS = 1'b0;
    localparam logic TYPE_ADDR   = 1'b1;

endpackage

// File: rtl/trc_rec_fmt.sv
module trc_rec_fmt #(
    parameter int FLOW_W  = 3,
    parameter int FLUSH_W = 2,
    parameter int ADDR_W  = 16,
    parameter int PAY_W   = 16
) (
    input  logic [FLOW_W-1:0]  flow_stat,
    input  logic [FLUSH_W-1:0] flush_stat,
    input  logic [ADDR_W-1:0]  bus_addr,
    output logic [PAY_W:0]     rec_status,
    output logic [PAY_W:0]     rec_addr
);
    import trc_pkg::*;

    always_comb begin
        rec_status = '0;
        rec_status[FLOW_W+FLUSH_W-1:0] = {flow_stat, flush_stat};
        rec_status[PAY_W] = TYPE_STATUS;

        rec_addr = '0;
        rec_addr[ADDR_W-1:0] = bus_addr;
        rec_addr[PAY_W] = TYPE_ADDR;
    end

endmodule

// File: rtl/trc_ring_mem.sv
module trc_ring_mem #(
    parameter int DEPTH = 32,
    parameter int REC_W = 17,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we_a,
    input  logic [PTR_W-1:0] wa_a,
    input  logic [REC_W-1:0] wd_a,
    input  logic             we_b,
    input  logic [PTR_W-1:0] wa_b,
    input  logic [REC_W-1:0] wd_b,
    input  logic [PTR_W-1:0] ra,
    output logic [REC_W-1:0] rd
);
    logic [REC_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (we_b && (wa_b == PTR_W'(i))) begin
                store[i] <= wd_b;
            end else if (we_a && (wa_a == PTR_W'(i))) begin
                store[i] <= wd_a;
            end
        end
    end

    assign rd = store[ra];

endmodule

// File: rtl/trc_ctrl.sv
module trc_ctrl #(
    parameter int DEPTH    = 32,
    parameter int POST_CYC = 0,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = (POST_CYC < 1) ? 1 : $clog2(POST_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    input  logic             host_clr,
    input  logic             mark,
    input  logic             rd_en,
    output logic             we_a,
    output logic             we_b,
    output logic [PTR_W-1:0] wa_a,
    output logic [PTR_W-1:0] wa_b,
    output logic [PTR_W-1:0] ra,
    output logic             frozen_o,
    output logic             full_o,
    output logic             rd_valid_o
);
    import trc_pkg::*;

    typedef struct packed {
        trc_state_e       st;
        logic             sync_q;
        logic [PTR_W-1:0] wr_ptr;
        logic             full;
        logic [CNT_W-1:0] cnt;
        logic [PTR_W-1:0] rd_ptr;
        logic [PTR_W:0]   rd_left;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    logic           capturing;
    logic           fall;
    logic           freeze_now;
    logic [PTR_W:0] sum;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.sync_q = sync_in;
        capturing  = (ctl_q.st != TRC_HOLD) && !host_clr;
        fall       = ctl_q.sync_q && !sync_in;
        freeze_now = 1'b0;

        we_a = capturing;
        we_b = capturing && mark;
        wa_a = ctl_q.wr_ptr;
        wa_b = ctl_q.wr_ptr + PTR_W'(1);

        sum = {1'b0, ctl_q.wr_ptr} + {{PTR_W{1'b0}}, we_a} + {{PTR_W{1'b0}}, we_b};
        ctl_d.wr_ptr = sum[PTR_W-1:0];
        if (sum[PTR_W]) begin
            ctl_d.full = 1'b1;
        end

        case (ctl_q.st)
            TRC_CAP: begin
                if (fall) begin
                    if (POST_CYC == 0) begin
                        freeze_now = 1'b1;
                    end else begin
                        ctl_d.st  = TRC_POST;
                        ctl_d.cnt = CNT_W'(POST_CYC);
                    end
                end
            end
            TRC_POST: begin
                if (ctl_q.cnt == CNT_W'(1)) begin
                    freeze_now = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - CNT_W'(1);
                end
            end
            default: begin
                if (rd_en && (ctl_q.rd_left != '0)) begin
                    ctl_d.rd_ptr  = ctl_q.rd_ptr + PTR_W'(1);
                    ctl_d.rd_left = ctl_q.rd_left - (PTR_W+1)'(1);
                end
            end
        endcase

        if (freeze_now) begin
            ctl_d.st      = TRC_HOLD;
            ctl_d.rd_ptr  = ctl_d.full ? ctl_d.wr_ptr : '0;
            ctl_d.rd_left = ctl_d.full ? (PTR_W+1)'(DEPTH) : {1'b0, ctl_d.wr_ptr};
        end

        if (host_clr) begin
            ctl_d        = '0;
            ctl_d.st     = TRC_CAP;
            ctl_d.sync_q = sync_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ra         = ctl_q.rd_ptr;
    assign frozen_o   = (ctl_q.st == TRC_HOLD);
    assign full_o     = ctl_q.full;
    assign rd_valid_o = (ctl_q.st == TRC_HOLD) && (ctl_q.rd_left != '0);

endmodule

// File: rtl/trace_ring_capture.sv
module trace_ring_capture #(
    parameter int FLOW_W   = 3,
    parameter int FLUSH_W  = 2,
    parameter int ADDR_W   = 16,
    parameter int DEPTH    = 32,
    parameter int POST_CYC = 0,
    localparam int PAY_W = (ADDR_W > FLOW_W + FLUSH_W) ? ADDR_W : FLOW_W + FLUSH_W,
    localparam int REC_W = PAY_W + 1,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FLOW_W-1:0]  flow_stat,
    input  logic [FLUSH_W-1:0] flush_stat,
    input  logic               trace_mark,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               sync_in,
    input  logic               host_clr,
    input  logic               rd_en,
    output logic [REC_W-1:0]   rd_data,
    output logic               rd_valid,
    output logic               frozen,
    output logic               full
);
    logic [REC_W-1:0] rec_status, rec_addr;
    logic             we_a, we_b;
    logic [PTR_W-1:0] wa_a, wa_b, ra;

    trc_rec_fmt #(
        .FLOW_W (FLOW_W),
        .FLUSH_W(FLUSH_W),
        .ADDR_W (ADDR_W),
        .PAY_W  (PAY_W)
    ) fmt_i (
        .flow_stat (flow_stat),
        .flush_stat(flush_stat),
        .bus_addr  (bus_addr),
        .rec_status(rec_status),
        .rec_addr  (rec_addr)
    );

    trc_ctrl #(
        .DEPTH   (DEPTH),
        .POST_CYC(POST_CYC)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_in   (sync_in),
        .host_clr  (host_clr),
        .mark      (trace_mark),
        .rd_en     (rd_en),
        .we_a      (we_a),
        .we_b      (we_b),
        .wa_a      (wa_a),
        .wa_b      (wa_b),
        .ra        (ra),
        .frozen_o  (frozen),
        .full_o    (full),
        .rd_valid_o(rd_valid)
    );

    trc_ring_mem #(
        .DEPTH(DEPTH),
        .REC_W(REC_W)
    ) mem_i (
        .clk (clk),
        .we_a(we_a),
        .wa_a(wa_a),
        .wd_a(rec_status),
        .we_b(we_b),
        .wa_b(wa_b),
        .wd_b(rec_addr),
        .ra  (ra),
        .rd  (rd_data)
    );

endmodule

// File: rtl/trace_ring_capture_chk.sv
module trace_ring_capture_chk #(
    parameter int REC_W    = 17,
    parameter int POST_CYC = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_in,
    input logic             host_clr,
    input logic             rd_en,
    input logic [REC_W-1:0] rd_data,
    input logic             rd_valid,
    input logic             frozen,
    input logic             full
);
    // R8: a clear leaves nothing frozen or full behind
    p_clear_rearms_r8: assert property (@(posedge clk) disable iff (!rst_n)
        host_clr |=> (!frozen && !full && !rd_valid));

    // R6: records are offered only from a frozen store
    p_valid_only_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> frozen);

    // R5: the wrap flag is sticky until a clear
    p_full_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !host_clr) |=> full);

    // R4: freeze is sticky until a clear
    p_frozen_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !host_clr) |=> frozen);

    // R6: without an advance the offered record holds still
    p_read_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_en && !host_clr) |=> (rd_valid && $stable(rd_data)));

    generate
        if (POST_CYC == 0) begin : g_immediate
            // R4: an immediate freeze follows a high-then-low sync
            p_freeze_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(frozen) |-> (!$past(sync_in) && $past(sync_in, 2)));
        end
    endgenerate

endmodule

bind trace_ring_capture trace_ring_capture_chk #(
    .REC_W   (REC_W),
    .POST_CYC(POST_CYC)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_in (sync_in),
    .host_clr(host_clr),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .rd_valid(rd_valid),
    .frozen  (frozen),
    .full    (full)
);

// File: tb/trace_ring_capture_tb_top.sv
`timescale 1ns/1ps
module trace_ring_capture_tb_top;
    localparam int FLOW_W  = 3;
    localparam int FLUSH_W = 2;
    localparam int ADDR_W  = 16;
    localparam int DEPTH   = 32;
    localparam int POST_N  = 3;
    localparam int REC_W   = ADDR_W + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [FLOW_W-1:0]  flow_stat = '0;
    logic [FLUSH_W-1:0] flush_stat = '0;
    logic               trace_mark = 1'b0;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic               sync_in = 1'b0;
    logic               host_clr = 1'b0;
    logic               rd_en_a = 1'b0, rd_en_b = 1'b0;
    logic [REC_W-1:0]   rd_data_a, rd_data_b;
    logic               rd_valid_a, rd_valid_b, frozen_a, frozen_b, full_a, full_b;

    always #10 clk = ~clk;

    trace_ring_capture #(.FLOW_W(FLOW_W), .FLUSH_W(FLUSH_W), .ADDR_W(ADDR_W),
                         .DEPTH(DEPTH), .POST_CYC(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .flow_stat(flow_stat), .flush_stat(flush_stat),
        .trace_mark(trace_mark), .bus_addr(bus_addr), .sync_in(sync_in),
        .host_clr(host_clr), .rd_en(rd_en_a), .rd_data(rd_data_a),
        .rd_valid(rd_valid_a), .frozen(frozen_a), .full(full_a));

    trace_ring_capture #(.FLOW_W(FLOW_W), .FLUSH_W(FLUSH_W), .ADDR_W(ADDR_W),
                         .DEPTH(DEPTH), .POST_CYC(POST_N)) dut_post_i (
        .clk(clk), .rst_n(rst_n), .flow_stat(flow_stat), .flush_stat(flush_stat),
        .trace_mark(trace_mark), .bus_addr(bus_addr), .sync_in(sync_in),
        .host_clr(host_clr), .rd_en(rd_en_b), .rd_data(rd_data_b),
        .rd_valid(rd_valid_b), .frozen(frozen_b), .full(full_b));

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [REC_W-1:0] hist_rec[$];
    int               hist_cyc[$];
    int               cyc = 0;
    int               ev_cyc = -1;
    logic             sy_prev = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [REC_W-1:0] exp_status(input logic [FLOW_W-1:0] f,
                                                     input logic [FLUSH_W-1:0] l);
        logic [REC_W-1:0] r;
        r = '0;
        r[4:2] = f;
        r[1:0] = l;
        return r;
    endfunction

    function automatic logic [REC_W-1:0] exp_addr(input logic [ADDR_W-1:0] a);
        return {1'b1, a};
    endfunction

    // one capture cycle: inputs set at falling edge, recorded at the rising edge
    task automatic step(input logic mk, input logic sy);
        flow_stat  = FLOW_W'($urandom);
        flush_stat = FLUSH_W'($urandom);
        bus_addr   = ADDR_W'($urandom);
        trace_mark = mk;
        sync_in    = sy;
        @(posedge clk);
        if (ev_cyc < 0 && sy_prev && !sy) ev_cyc = cyc;
        if (ev_cyc < 0 || cyc <= ev_cyc + POST_N) begin
            hist_rec.push_back(exp_status(flow_stat, flush_stat));
            hist_cyc.push_back(cyc);
            if (mk) begin
                hist_rec.push_back(exp_addr(bus_addr));
                hist_cyc.push_back(cyc);
            end
        end
        sy_prev = sy;
        cyc++;
        @(negedge clk);
    endtask

    task automatic clear_all();
        host_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        host_clr = 1'b0;
        hist_rec.delete();
        hist_cyc.delete();
        cyc = 0;
        ev_cyc = -1;
        sy_prev = sync_in;
    endtask

    // expected contents: records up to the freeze cycle, last DEPTH of them
    task automatic drain(input bit post, input string req);
        logic [REC_W-1:0] exp_q[$];
        int lim;
        int got;
        lim = ev_cyc + (post ? POST_N : 0);
        for (int i = 0; i < hist_rec.size(); i++)
            if (hist_cyc[i] <= lim) exp_q.push_back(hist_rec[i]);
        while (exp_q.size() > DEPTH) void'(exp_q.pop_front());
        got = 0;
        for (int i = 0; i < exp_q.size(); i++) begin
            logic v;
            logic [REC_W-1:0] d;
            v = post ? rd_valid_b : rd_valid_a;
            d = post ? rd_data_b : rd_data_a;
            chk(v == 1'b1, {req, " valid"}, 64'(v), 64'(1));
            chk(d == exp_q[i], {req, " record"}, 64'(d), 64'(exp_q[i]));
            if (post) rd_en_b = 1'b1; else rd_en_a = 1'b1;
            @(posedge clk);
            @(negedge clk);
            rd_en_a = 1'b0;
            rd_en_b = 1'b0;
            got++;
        end
        chk((post ? rd_valid_b : rd_valid_a) == 1'b0, {req, " end of records"},
            64'(post ? rd_valid_b : rd_valid_a), 64'(0));
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0101));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(!frozen_a && !full_a && !rd_valid_a, "R1 reset main",
            64'({frozen_a, full_a, rd_valid_a}), 64'(0));
        chk(!frozen_b && !full_b && !rd_valid_b, "R1 reset post",
            64'({frozen_b, full_b, rd_valid_b}), 64'(0));

        // Scenario A: short history, R7 rd_en during capture
        step(1'b1, 1'b0);
        rd_en_a = 1'b1;
        rd_en_b = 1'b1;
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        rd_en_a = 1'b0;
        rd_en_b = 1'b0;
        for (int i = 0; i < 9; i++) step(1'($urandom_range(0, 1)), 1'b1);
        step(1'b1, 1'b0);  // R4 event
        chk(frozen_a == 1'b1, "R4 freeze at event", 64'(frozen_a), 64'(1));
        chk(frozen_b == 1'b0, "R9 post still capturing", 64'(frozen_b), 64'(0));
        step(1'b1, 1'b1);
        step(1'b0, 1'b0);
        chk(frozen_b == 1'b0, "R9 post capturing at N-1", 64'(frozen_b), 64'(0));
        step(1'b1, 1'b1);
        chk(frozen_b == 1'b1, "R9 post frozen at N", 64'(frozen_b), 64'(1));
        for (int i = 0; i < 3; i++) step(1'b1, 1'($urandom_range(0, 1)));
        chk(full_a == 1'b0, "R5 not full before wrap", 64'(full_a), 64'(0));
        drain(1'b0, "R2 R3 R6 R7 main short");
        drain(1'b1, "R9 post short");

        // R8 clear
        sync_in = 1'b0;
        clear_all();
        chk(!frozen_a && !full_a && !rd_valid_a, "R8 clear main",
            64'({frozen_a, full_a, rd_valid_a}), 64'(0));
        chk(!frozen_b && !full_b && !rd_valid_b, "R8 clear post",
            64'({frozen_b, full_b, rd_valid_b}), 64'(0));

        // Scenario B: low sync without prior high, then long wrapping run
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
        chk(frozen_a == 1'b0, "R4 low sync without high ignored", 64'(frozen_a), 64'(0));
        for (int i = 0; i < 60; i++) step(1'($urandom_range(0, 1)), 1'b1);
        step(1'($urandom_range(0, 1)), 1'b0);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1);
        chk(full_a == 1'b1, "R5 full after wrap", 64'(full_a), 64'(1));
        chk(frozen_a == 1'b1, "R4 frozen after long run", 64'(frozen_a), 64'(1));
        drain(1'b0, "R5 R6 main wrapped");
        drain(1'b1, "R9 post wrapped");

        // Scenario C: event lands exactly on the wrap (32 records)
        sync_in = 1'b0;
        clear_all();
        for (int i = 0; i < 15; i++) step(1'b1, 1'b1);
        chk(full_a == 1'b0, "R5 30 records not full", 64'(full_a), 64'(0));
        step(1'b1, 1'b0);
        chk(full_a == 1'b1, "R5 exact wrap full", 64'(full_a), 64'(1));
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1);
        drain(1'b0, "R5 R6 main exact wrap");
        drain(1'b1, "R9 post exact wrap");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule